// File: doc/BRIEF.md
# Laser Array Bring-Up and Shutdown Sequencer

This block supervises an array of laser channels. It watches a supply-good flag, an active-low control reset, an enable/disable pair and three kinds of fault flag: a per-channel over-current vector, an out-of-range temperature flag and a calibration-corruption flag. It drives a shutdown line and a complementary run line for every channel, plus an active-low fault output. All delays are counted in clock cycles and set by parameters.

Channels are released from shutdown one at a time in ascending index order. The first channel waits a long settling delay after the supply comes good, or a shorter delay after a control reset is released or after the array is enabled again. Every loss of a run condition darkens all channels at the next clock edge. A fault stays latched until the control reset or the supply flag drops. The conditions are checked in a fixed priority: supply, then control reset, then fault, then disable.

States: `ST_NOPWR` (supply low), `ST_RESET` (control reset held), `ST_FAULT` (fault latched), `ST_HOLD` (disabled, counting the minimum dark time), `ST_DELAY` (waiting for the first channel), `ST_STEP` (releasing further channels), `ST_RUN` (all channels up). Transitions: any state goes to `ST_NOPWR` on supply low, to `ST_RESET` on control reset, to `ST_FAULT` on a latched or new fault, and to `ST_HOLD` on disable. `ST_NOPWR` and `ST_RESET` go to `ST_DELAY` when every condition is good. `ST_HOLD` goes to `ST_DELAY` once the minimum dark time has elapsed and the array is enabled. `ST_DELAY` goes to `ST_STEP` when the first channel is released. `ST_STEP` goes to `ST_RUN` when the last channel is released.

Top module: `txarr_seq`

## Requirements
- R1: A channel's run line (`ch_norm`) is 1 only while `tx_en` is 1 and `tx_dis` is 0. When either of these leaves its run value, every run line is 0 after the next clock edge.
- R2: After a disable, the array stays dark for at least `MIN_OFF` cycles. Restart begins on the edge at which the dark counter has reached `MIN_OFF` while the array is enabled. The counter starts at 0 on the first disabled edge.
- R3: An over-current on any channel, the temperature flag or the calibration flag sets the fault latch at the next edge. At that same edge `fault_n` goes to 0 and all channels go dark.
- R4: A latched fault stays set while its source is gone and while the array is disabled or re-enabled. Only `tx_rst_n` low or `supply_ok` low clears it.
- R5: While `tx_rst_n` is 0, all channels are dark and `fault_n` is 1 one edge after it is sampled low, even if a fault flag is still active. A low pulse of a single cycle is accepted.
- R6: After `supply_ok` is sampled 1 from the supply-low state, channel 0 is released `PWR_DLY` edges later. The long delay keeps applying until a first channel has come up since the supply became good.
- R7: After `tx_rst_n` is released, or after the minimum dark time ends, channel 0 is released `RST_DLY` edges after the first edge of the delay state.
- R8: Channel i is released `STEP_DLY`·i edges after channel 0. Channels come up one at a time in ascending order, so the set of run lines is always a run of ones starting at bit 0.
- R9: A disable, a reset or a fault during the staggered release aborts it. The next release starts again from channel 0.
- R10: `supply_ok` at 0 acts as a supply cycle. It darkens all channels, clears the fault and re-arms the long power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low block reset |
| supply_ok | input | 1 | Supply-good flag |
| tx_rst_n | input | 1 | Active-low control reset |
| tx_en | input | 1 | Array enable, active high |
| tx_dis | input | 1 | Array disable, active high |
| oc_flt | input | NCH | Per-channel over-current flags |
| temp_flt | input | 1 | Temperature out of range |
| cal_flt | input | 1 | Calibration data corrupt |
| ch_shdn | output | NCH | Per-channel shutdown, 1 = dark |
| ch_norm | output | NCH | Per-channel run, complement of `ch_shdn` |
| fault_n | output | 1 | Latched fault, active low |

## Verification
A counter or state error shows on the ports as a channel that comes up an edge early or late. It can also show as a run line that appears out of order, so the bench samples the channel count on the exact release edges and one edge before them. A wrong priority or a wrong latch condition shows within one edge: `fault_n` moves when it must not, or the array stays lit after a disable. The minimum dark time and the cold-start flag can only be seen much later, at the release of channel 0, so those cases check the release edge well after the stimulus.

// File: rtl/txarr_pkg.sv
package txarr_pkg;

    typedef enum logic [2:0] {
        ST_NOPWR = 3'd0,
        ST_RESET = 3'd1,
        ST_FAULT = 3'd2,
        ST_HOLD  = 3'd3,
        ST_DELAY = 3'd4,
        ST_STEP  = 3'd5,
        ST_RUN   = 3'd6
    } seq_state_t;

endpackage

// File: rtl/txarr_fault_latch.sv
module txarr_fault_latch #(
    parameter int NCH = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [NCH-1:0] oc_flt,
    input  logic           temp_flt,
    input  logic           cal_flt,
    output logic           flt_any,
    output logic           latched
);

    assign flt_any = (|oc_flt) | temp_flt | cal_flt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            latched <= 1'b0;
        else if (clr)
            latched <= 1'b0;
        else if (flt_any)
            latched <= 1'b1;
    end

    // R4: the latch falls only after a clear request
    assert_fault_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(latched) |-> $past(clr));

    // R3: a fault flag without a clear sets the latch at the next edge
    assert_fault_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_any && !clr) |=> latched);

endmodule

// File: rtl/txarr_chan_mask.sv
module txarr_chan_mask #(
    parameter int NCH = 12,
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_all,
    input  logic          set_en,
    input  logic [IW-1:0] set_idx,
    output logic [NCH-1:0] on_mask
);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                on_mask[i] <= 1'b0;
            else if (clr_all)
                on_mask[i] <= 1'b0;
            else if (set_en && (set_idx == IW'(i)))
                on_mask[i] <= 1'b1;
        end
    end

    // R8: lit channels always form a run of ones from bit 0
    assert_in_order_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (on_mask & (on_mask + 1'b1)) == '0);

endmodule

// File: rtl/txarr_seq.sv
module txarr_seq
    import txarr_pkg::*;
#(
    parameter int NCH      = 12,
    parameter int PWR_DLY  = 15000000,
    parameter int RST_DLY  = 13750000,
    parameter int STEP_DLY = 1150000,
    parameter int MIN_OFF  = 250000
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           supply_ok,
    input  logic           tx_rst_n,
    input  logic           tx_en,
    input  logic           tx_dis,
    input  logic [NCH-1:0] oc_flt,
    input  logic           temp_flt,
    input  logic           cal_flt,
    output logic [NCH-1:0] ch_shdn,
    output logic [NCH-1:0] ch_norm,
    output logic           fault_n
);

    localparam int MAX_A = (PWR_DLY > RST_DLY) ? PWR_DLY : RST_DLY;
    localparam int MAX_B = (STEP_DLY > MIN_OFF) ? STEP_DLY : MIN_OFF;
    localparam int MAXD  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAXD + 1);
    localparam int IW    = (NCH > 1) ? $clog2(NCH) : 1;

    localparam logic [CW-1:0] K_PWR  = CW'(PWR_DLY - 1);
    localparam logic [CW-1:0] K_RST  = CW'(RST_DLY - 1);
    localparam logic [CW-1:0] K_STEP = CW'(STEP_DLY - 1);
    localparam logic [CW-1:0] K_OFF  = CW'(MIN_OFF);
    localparam logic [IW-1:0] K_LAST = IW'(NCH - 1);

    seq_state_t      state, nxt_state;
    logic [CW-1:0]   cnt, nxt_cnt;
    logic [IW-1:0]   idx, nxt_idx;
    logic            cold, nxt_cold;
    logic            set_en, clr_all;
    logic            flt_any, latched, flt_clr, run_ok;
    logic [NCH-1:0]  on_mask;

    assign flt_clr = ~supply_ok | ~tx_rst_n;
    assign run_ok  = tx_en & ~tx_dis;

    txarr_fault_latch #(.NCH(NCH)) u_flt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (flt_clr),
        .oc_flt   (oc_flt),
        .temp_flt (temp_flt),
        .cal_flt  (cal_flt),
        .flt_any  (flt_any),
        .latched  (latched)
    );

    txarr_chan_mask #(.NCH(NCH)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_all (clr_all),
        .set_en  (set_en),
        .set_idx (idx),
        .on_mask (on_mask)
    );

    always_comb begin
        nxt_state = state;
        nxt_cnt   = cnt;
        nxt_idx   = idx;
        nxt_cold  = cold;
        set_en    = 1'b0;
        clr_all   = 1'b0;
        if (!supply_ok) begin
            nxt_state = ST_NOPWR;
            nxt_cnt   = '0;
            nxt_idx   = '0;
            nxt_cold  = 1'b1;
            clr_all   = 1'b1;
        end else if (!tx_rst_n) begin
            nxt_state = ST_RESET;
            nxt_cnt   = '0;
            nxt_idx   = '0;
            clr_all   = 1'b1;
        end else if (latched || flt_any) begin
            nxt_state = ST_FAULT;
            nxt_cnt   = '0;
            nxt_idx   = '0;
            clr_all   = 1'b1;
        end else if (!run_ok) begin
            clr_all = 1'b1;
            nxt_idx = '0;
            if (state != ST_HOLD) begin
                nxt_state = ST_HOLD;
                nxt_cnt   = '0;
            end else if (cnt != K_OFF) begin
                nxt_cnt = cnt + 1'b1;
            end
        end else begin
            unique case (state)
                ST_NOPWR, ST_RESET, ST_FAULT: begin
                    nxt_state = ST_DELAY;
                    nxt_cnt   = '0;
                    nxt_idx   = '0;
                end
                ST_HOLD: begin
                    if (cnt == K_OFF) begin
                        nxt_state = ST_DELAY;
                        nxt_cnt   = '0;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (cnt == (cold ? K_PWR : K_RST)) begin
                        set_en    = 1'b1;
                        nxt_cold  = 1'b0;
                        nxt_cnt   = '0;
                        nxt_idx   = IW'(1);
                        nxt_state = (NCH > 1) ? ST_STEP : ST_RUN;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_STEP: begin
                    if (cnt == K_STEP) begin
                        set_en  = 1'b1;
                        nxt_cnt = '0;
                        if (idx == K_LAST)
                            nxt_state = ST_RUN;
                        else
                            nxt_idx = idx + 1'b1;
                    end else begin
                        nxt_cnt = cnt + 1'b1;
                    end
                end
                ST_RUN: begin
                    nxt_cnt = '0;
                end
                default: begin
                    nxt_state = ST_NOPWR;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_NOPWR;
            cnt   <= '0;
            idx   <= '0;
            cold  <= 1'b1;
        end else begin
            state <= nxt_state;
            cnt   <= nxt_cnt;
            idx   <= nxt_idx;
            cold  <= nxt_cold;
        end
    end

    always_comb begin
        ch_norm = on_mask;
        ch_shdn = ~on_mask;
        fault_n = ~latched;
    end

    // R3: a latched fault never coexists with a lit channel
    assert_fault_dark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        latched |-> (on_mask == '0));

    // R1: a disable darkens the array by the next edge
    assert_dis_dark_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en || tx_dis) |=> (on_mask == '0));

    // R8: at most one channel is released per edge
    assert_one_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(on_mask) <= $countones($past(on_mask)) + 1);

    // R10: supply low darkens the array and clears the fault by the next edge
    assert_supply_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (on_mask == '0) && !latched);

endmodule

// File: tb/sim_txarr_seq.sv
`timescale 1ns/1ps
module sim_txarr_seq;

    localparam int NCH = 12;

    typedef struct packed {
        int sup; int rstn; int en; int dis; int temp; int cal;
        int ocv; int oci; int w; int n; int fn; int req;
    } row_t;

    // sup rstn en dis temp cal ocv oci wait nOn fault_n req
    localparam row_t TBL [27] = '{
        '{1,1,1,0,0,0,0,0, 40, 0,1, 6},  // R6 one edge before channel 0
        '{1,1,1,0,0,0,0,0,  1, 1,1, 6},  // R6 channel 0 on the delay edge
        '{1,1,1,0,0,0,0,0,  5, 2,1, 8},  // R8 channel 1
        '{1,1,1,0,0,0,0,0,  4, 2,1, 8},  // R8 one edge early
        '{1,1,1,0,0,0,0,0,  1, 3,1, 8},  // R8 channel 2
        '{1,1,1,0,0,0,0,0, 60,12,1, 8},  // R8 all up
        '{1,1,1,1,0,0,0,0,  1, 0,1, 1},  // R1 disable darkens
        '{1,1,1,0,0,0,0,0, 54, 0,1, 2},  // R2 minimum dark time plus restart delay
        '{1,1,1,0,0,0,0,0,  1, 1,1, 7},  // R7 channel 0 back
        '{1,1,1,0,0,0,0,0, 60,12,1, 8},  // R8 all up
        '{1,1,0,0,0,0,0,0,  2, 0,1, 1},  // R1 enable low darkens
        '{1,1,1,0,0,0,0,0, 53, 0,1, 2},  // R2 short disable still waits
        '{1,1,1,0,0,0,0,0,  1, 1,1, 7},  // R7
        '{1,1,1,0,0,0,0,0, 10, 3,1, 8},  // R8
        '{1,1,1,0,1,0,0,0,  1, 0,0, 3},  // R3 temperature fault mid-sequence
        '{1,1,1,0,0,0,0,0,100, 0,0, 4},  // R4 stays latched
        '{1,0,1,0,0,0,0,0,  1, 0,1, 5},  // R5 reset clears
        '{1,1,1,0,0,0,0,0, 24, 0,1, 7},  // R7 one edge before
        '{1,1,1,0,0,0,0,0,  1, 1,1, 7},  // R7 short delay after reset
        '{1,1,1,0,0,0,0,0,100,12,1, 8},  // R8
        '{1,1,1,0,0,0,1,5,  1, 0,0, 3},  // R3 over-current on channel 5
        '{0,1,1,0,0,0,0,0,  1, 0,1,10},  // R10 supply low clears
        '{1,1,1,0,0,0,0,0, 40, 0,1,10},  // R10 long delay re-armed
        '{1,1,1,0,0,0,0,0,  1, 1,1, 6},  // R6
        '{1,1,1,0,0,1,0,0,  1, 0,0, 3},  // R3 calibration fault
        '{1,1,0,0,0,0,0,0, 50, 0,0, 4},  // R4 disable does not clear
        '{1,1,1,0,0,0,0,0, 80, 0,0, 4}   // R4 enable does not clear
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b0, tx_rst_n = 1'b1, tx_en = 1'b1, tx_dis = 1'b0;
    logic [NCH-1:0] oc_flt = '0;
    logic temp_flt = 1'b0, cal_flt = 1'b0;
    logic [NCH-1:0] ch_shdn, ch_norm;
    logic fault_n;
    int total = 0, bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    txarr_seq #(.NCH(NCH), .PWR_DLY(40), .RST_DLY(24), .STEP_DLY(5), .MIN_OFF(30)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .tx_rst_n(tx_rst_n),
        .tx_en(tx_en), .tx_dis(tx_dis), .oc_flt(oc_flt), .temp_flt(temp_flt),
        .cal_flt(cal_flt), .ch_shdn(ch_shdn), .ch_norm(ch_norm), .fault_n(fault_n)
    );

    task automatic check(input int req, input int n_on, input logic exp_fn);
        logic [NCH-1:0] m;
        m = '0;
        for (int k = 0; k < n_on; k++) m[k] = 1'b1;
        total++;
        if (ch_norm !== m || ch_shdn !== ~m || fault_n !== exp_fn) begin
            bad++;
            $display("FAIL R%0d: norm=%b shdn=%b fault_n=%b expected norm=%b shdn=%b fault_n=%b",
                     req, ch_norm, ch_shdn, fault_n, m, ~m, exp_fn);
        end
    endtask

    task automatic step(input int w);
        repeat (w) @(negedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        check(5, 0, 1'b1);          // reset state: all dark, no fault
        rst_n = 1'b1;
        step(2);
        check(10, 0, 1'b1);         // R10 supply still low
        for (int i = 0; i < 27; i++) begin
            supply_ok = TBL[i].sup[0];
            tx_rst_n  = TBL[i].rstn[0];
            tx_en     = TBL[i].en[0];
            tx_dis    = TBL[i].dis[0];
            temp_flt  = TBL[i].temp[0];
            cal_flt   = TBL[i].cal[0];
            oc_flt    = TBL[i].ocv[0] ? (NCH'(1) << TBL[i].oci) : '0;
            step(TBL[i].w);
            check(TBL[i].req, TBL[i].n, TBL[i].fn[0]);
        end
        // R5: reset wins over an active fault flag
        cal_flt = 1'b1; tx_rst_n = 1'b0;
        step(3);
        check(5, 0, 1'b1);
        tx_rst_n = 1'b1;
        step(1);
        check(3, 0, 1'b0);          // R3 re-latches on release
        cal_flt = 1'b0; tx_rst_n = 1'b0;
        step(1);                    // R5 single-cycle reset pulse
        tx_rst_n = 1'b1;
        step(1);
        check(5, 0, 1'b1);
        step(23);
        check(7, 0, 1'b1);
        step(1);
        check(7, 1, 1'b1);
        step(5);
        check(8, 2, 1'b1);
        tx_dis = 1'b1;              // R9 abort mid-sequence
        step(1);
        check(9, 0, 1'b1);
        tx_dis = 1'b0;
        step(54);
        check(9, 0, 1'b1);
        step(1);
        check(9, 1, 1'b1);          // R9 restart from channel 0 only
        step(5);
        check(9, 2, 1'b1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule